// File: doc/BRIEF.md
# 128-bit Lane Permute and Pack Unit

This unit rearranges the lanes of two 128-bit operands into a single 128-bit result. Each issue supplies two operands together with their register indices, a permute opcode, a lane size and a destination index. The unit applies one of seven fixed shuffles: pack words, interleave lower lanes, interleave upper words, copy halfword, copy lower doubleword, copy upper doubleword and rotate three words. It returns the result one clock later with the destination index and a write enable. The network itself is pure wiring and multiplexing. The only state is the output register.

Register index 0 is the hard-wired zero register. An operand whose source index is 0 is replaced by all zeros, whatever its data input carries. A destination index of 0 never raises the write enable.

Top module: `lane_permute_unit`

## Requirements
- R1: While reset is asserted, and after its release until the first qualifying issue, `wr_en_o` is 0.
- R2: Opcode 0 (pack words) gives result words, from least significant up: rt word0, rt word2, rs word0, rs word2 (word k is bits 32k+31..32k).
- R3: Opcode 1 (interleave lower) takes lanes from the low 64 bits of rt and rs and alternates them starting with rt: result lane 2i is rt lane i and lane 2i+1 is rs lane i, filling from bit 0 upward. Lane size code 0 selects bytes, 1 selects halfwords, and 2 or 3 select words.
- R4: Opcode 2 (interleave upper words) gives result words rt word2, rs word2, rt word3, rs word3, from least significant up.
- R5: Opcode 3 (copy halfword) replicates bits 15:0 of rt into all four halfwords of result[63:0], and bits 79:64 of rt into all four halfwords of result[127:64].
- R6: Opcode 4 (copy lower doubleword) gives result[63:0] = rt[63:0] and result[127:64] = rs[63:0].
- R7: Opcode 5 (copy upper doubleword) gives result[63:0] = rs[127:64] and result[127:64] = rt[127:64].
- R8: Opcode 6 (rotate three words) maps rt words [w0,w1,w2,w3] to result words [w1,w2,w0,w3], so word 3 passes unchanged.
- R9: An issue with destination index 0 leaves `wr_en_o` at 0 in the following cycle.
- R10: A source index of 0 makes that operand read as all zeros, whatever its data input carries.
- R11: Opcode 7 is reserved. It produces an all-zero result and leaves `wr_en_o` at 0.
- R12: The result, destination index and write enable appear exactly one cycle after the issue. A cycle without an issue drops `wr_en_o` and holds `result_o` and `dst_idx_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_i | input | 1 | Issue strobe; the other inputs are valid when it is high |
| opcode_i | input | 3 | Permute opcode (0 to 6 as in R2 to R8; 7 is reserved) |
| lane_sz_i | input | 2 | Lane size for interleave lower: 0 byte, 1 halfword, 2 or 3 word |
| rs_idx_i | input | 5 | Register index of the first operand; 0 reads as zero |
| rt_idx_i | input | 5 | Register index of the second operand; 0 reads as zero |
| rs_data_i | input | 128 | First operand data |
| rt_data_i | input | 128 | Second operand data |
| dst_idx_i | input | 5 | Destination register index |
| result_o | output | 128 | Registered permute result |
| dst_idx_o | output | 5 | Registered destination index |
| wr_en_o | output | 1 | Write enable for the destination, high for one cycle per qualifying issue |

## Verification
The assertions check the following on every cycle:
- the write enable never rises for destination 0, for the reserved opcode or without an issue in the previous cycle;
- the output register holds between issues;
- the top word passes through on a rotate;
- a zero source index empties the upper half of a lower-doubleword copy.

The exact lane orderings of each shuffle, and every lane size of the lower interleave, can only be shown by the bench's scenarios, which compare each result with an independent per-bit model. The same holds for the reset behaviour and the hold of the result across idle cycles.

// File: rtl/lpu_pkg.sv
package lpu_pkg;

  typedef enum logic [2:0] {
    OP_PACK_W    = 3'd0,
    OP_ILV_LO    = 3'd1,
    OP_ILV_HI_W  = 3'd2,
    OP_COPY_H    = 3'd3,
    OP_COPY_LO_D = 3'd4,
    OP_COPY_HI_D = 3'd5,
    OP_ROT3_W    = 3'd6,
    OP_RSVD      = 3'd7
  } perm_op_e;

  typedef enum logic [1:0] {
    LANE_BYTE = 2'd0,
    LANE_HALF = 2'd1,
    LANE_WORD = 2'd2,
    LANE_WALT = 2'd3
  } lane_sz_e;

  localparam int unsigned NUM_LANE_VARIANTS = 3;

endpackage

// File: rtl/lpu_src_gate.sv
module lpu_src_gate #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);

  logic idx_is_zero;

  always_comb begin
    idx_is_zero = (idx_i == '0);
    data_o      = idx_is_zero ? '0 : data_i;
  end

endmodule

// File: rtl/lpu_interleave.sv
module lpu_interleave #(
  parameter int unsigned DATA_W = 128
) (
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  input  logic [1:0]        lane_sz_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_w_o
);

  import lpu_pkg::*;

  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned WORD_W = DATA_W / 4;

  logic [NUM_LANE_VARIANTS-1:0][DATA_W-1:0] ilv_var;

  // One wiring pattern per lane size; lane index s gives width 8 << s.
  for (genvar s = 0; s < NUM_LANE_VARIANTS; s++) begin : g_size
    localparam int unsigned LW = 8 << s;
    for (genvar i = 0; i < HALF_W / LW; i++) begin : g_lane
      assign ilv_var[s][(2*i)*LW   +: LW] = rt_i[i*LW +: LW];
      assign ilv_var[s][(2*i+1)*LW +: LW] = rs_i[i*LW +: LW];
    end
  end

  always_comb begin
    unique case (lane_sz_e'(lane_sz_i))
      LANE_BYTE: lo_o = ilv_var[0];
      LANE_HALF: lo_o = ilv_var[1];
      default:   lo_o = ilv_var[2];
    endcase
  end

  // Word interleave on the upper halves.
  for (genvar i = 0; i < HALF_W / WORD_W; i++) begin : g_hi
    assign hi_w_o[(2*i)*WORD_W   +: WORD_W] = rt_i[HALF_W + i*WORD_W +: WORD_W];
    assign hi_w_o[(2*i+1)*WORD_W +: WORD_W] = rs_i[HALF_W + i*WORD_W +: WORD_W];
  end

endmodule

// File: rtl/lpu_shuffle.sv
module lpu_shuffle #(
  parameter int unsigned DATA_W = 128
) (
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  output logic [DATA_W-1:0] pack_w_o,
  output logic [DATA_W-1:0] copy_h_o,
  output logic [DATA_W-1:0] copy_lo_d_o,
  output logic [DATA_W-1:0] copy_hi_d_o,
  output logic [DATA_W-1:0] rot3_w_o
);

  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned WORD_W = DATA_W / 4;
  localparam int unsigned HW_W   = DATA_W / 8;
  localparam int unsigned HW_PER_HALF = HALF_W / HW_W;

  logic [3:0][WORD_W-1:0] rs_w, rt_w;

  always_comb begin
    rs_w = rs_i;
    rt_w = rt_i;
    pack_w_o    = {rs_w[2], rs_w[0], rt_w[2], rt_w[0]};
    copy_lo_d_o = {rs_i[HALF_W-1:0], rt_i[HALF_W-1:0]};
    copy_hi_d_o = {rt_i[DATA_W-1:HALF_W], rs_i[DATA_W-1:HALF_W]};
    rot3_w_o    = {rt_w[3], rt_w[0], rt_w[2], rt_w[1]};
  end

  // Halfword broadcast inside each 64-bit half.
  for (genvar h = 0; h < 2; h++) begin : g_half
    for (genvar j = 0; j < HW_PER_HALF; j++) begin : g_hw
      assign copy_h_o[h*HALF_W + j*HW_W +: HW_W] = rt_i[h*HALF_W +: HW_W];
    end
  end

endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [2:0]        opcode_i,
  input  logic [1:0]        lane_sz_i,
  input  logic [IDX_W-1:0]  rs_idx_i,
  input  logic [IDX_W-1:0]  rt_idx_i,
  input  logic [DATA_W-1:0] rs_data_i,
  input  logic [DATA_W-1:0] rt_data_i,
  input  logic [IDX_W-1:0]  dst_idx_i,
  output logic [DATA_W-1:0] result_o,
  output logic [IDX_W-1:0]  dst_idx_o,
  output logic              wr_en_o
);

  import lpu_pkg::*;

  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned WORD_W = DATA_W / 4;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [DATA_W-1:0] rs_eff, rt_eff;

  lpu_src_gate #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_gate_rs (
    .idx_i(rs_idx_i), .data_i(rs_data_i), .data_o(rs_eff)
  );
  lpu_src_gate #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_gate_rt (
    .idx_i(rt_idx_i), .data_i(rt_data_i), .data_o(rt_eff)
  );

  logic [DATA_W-1:0] ilv_lo, ilv_hi_w;

  lpu_interleave #(.DATA_W(DATA_W)) u_ilv (
    .rs_i(rs_eff), .rt_i(rt_eff), .lane_sz_i(lane_sz_i),
    .lo_o(ilv_lo), .hi_w_o(ilv_hi_w)
  );

  logic [DATA_W-1:0] pack_w, copy_h, copy_lo_d, copy_hi_d, rot3_w;

  lpu_shuffle #(.DATA_W(DATA_W)) u_shuf (
    .rs_i(rs_eff), .rt_i(rt_eff),
    .pack_w_o(pack_w), .copy_h_o(copy_h), .copy_lo_d_o(copy_lo_d),
    .copy_hi_d_o(copy_hi_d), .rot3_w_o(rot3_w)
  );

  // Next state
  perm_op_e          op;
  logic [DATA_W-1:0] result_d;
  logic              wr_en_d;

  always_comb begin
    op = perm_op_e'(opcode_i);
    unique case (op)
      OP_PACK_W:    result_d = pack_w;
      OP_ILV_LO:    result_d = ilv_lo;
      OP_ILV_HI_W:  result_d = ilv_hi_w;
      OP_COPY_H:    result_d = copy_h;
      OP_COPY_LO_D: result_d = copy_lo_d;
      OP_COPY_HI_D: result_d = copy_hi_d;
      OP_ROT3_W:    result_d = rot3_w;
      default:      result_d = '0;
    endcase
    wr_en_d = issue_i && (dst_idx_i != '0) && (op != OP_RSVD);
  end

  // Registers
  logic [DATA_W-1:0] result_q;
  logic [IDX_W-1:0]  dst_q;
  logic              wr_en_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) wr_en_q <= 1'b0;
    else             wr_en_q <= wr_en_d;
  end

  always_ff @(posedge clk) begin
    if (issue_i) begin
      result_q <= result_d;
      dst_q    <= dst_idx_i;
    end
  end

  assign result_o  = result_q;
  assign dst_idx_o = dst_q;
  assign wr_en_o   = wr_en_q;

  // Assertions
  AST_NO_WRITE_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    issue_i && (dst_idx_i == '0) |=> !wr_en_o); // R9
  AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    issue_i && (opcode_i == 3'd7) |=> !wr_en_o && (result_o == '0)); // R11
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !issue_i |=> !wr_en_o); // R12
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !issue_i |=> $stable(result_o) && $stable(dst_idx_o)); // R12
  AST_ROT3_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    issue_i && (opcode_i == 3'd6) |=>
      result_o[DATA_W-1 -: WORD_W] == $past(rt_eff[DATA_W-1 -: WORD_W])); // R8
  AST_ZERO_SRC_EMPTY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    issue_i && (opcode_i == 3'd4) && (rs_idx_i == '0) |=>
      result_o[DATA_W-1:HALF_W] == '0); // R10

endmodule

// File: tb/lane_permute_unit_tb.sv
module lane_permute_unit_tb;

  localparam int unsigned DW = 128;

  typedef struct packed {
    logic [3:0]    req;
    logic [2:0]    op;
    logic [1:0]    lsz;
    logic [4:0]    rsi;
    logic [4:0]    rti;
    logic [4:0]    dst;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
  } vec_t;

  localparam logic [DW-1:0] P_A = 128'hAFAEADACABAAA9A8A7A6A5A4A3A2A1A0;
  localparam logic [DW-1:0] P_B = 128'h0F0E0D0C0B0A09080706050403020100;
  localparam logic [DW-1:0] P_C = 128'hDEADBEEF0123456789ABCDEFCAFEF00D;
  localparam logic [DW-1:0] P_D = 128'h11112222333344445555666677778888;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  3'd0, 2'd0, 5'd3, 5'd4, 5'd7,  P_A, P_B}, // R2
    '{4'd2,  3'd0, 2'd0, 5'd3, 5'd4, 5'd8,  P_C, P_D}, // R2
    '{4'd3,  3'd1, 2'd0, 5'd3, 5'd4, 5'd9,  P_A, P_B}, // R3 byte
    '{4'd3,  3'd1, 2'd1, 5'd3, 5'd4, 5'd10, P_A, P_B}, // R3 half
    '{4'd3,  3'd1, 2'd2, 5'd3, 5'd4, 5'd11, P_C, P_D}, // R3 word
    '{4'd3,  3'd1, 2'd3, 5'd3, 5'd4, 5'd12, P_A, P_C}, // R3 word alt
    '{4'd4,  3'd2, 2'd0, 5'd3, 5'd4, 5'd13, P_A, P_B}, // R4
    '{4'd5,  3'd3, 2'd0, 5'd3, 5'd4, 5'd14, P_A, P_B}, // R5
    '{4'd5,  3'd3, 2'd0, 5'd3, 5'd4, 5'd15, P_C, P_D}, // R5
    '{4'd6,  3'd4, 2'd0, 5'd3, 5'd4, 5'd16, P_A, P_B}, // R6
    '{4'd7,  3'd5, 2'd0, 5'd3, 5'd4, 5'd17, P_A, P_B}, // R7
    '{4'd8,  3'd6, 2'd0, 5'd3, 5'd4, 5'd18, P_A, P_B}, // R8
    '{4'd8,  3'd6, 2'd0, 5'd3, 5'd4, 5'd31, P_D, P_C}, // R8
    '{4'd10, 3'd4, 2'd0, 5'd0, 5'd4, 5'd19, P_A, P_B}, // R10 rs zero
    '{4'd10, 3'd6, 2'd0, 5'd3, 5'd0, 5'd20, P_A, P_B}, // R10 rt zero
    '{4'd10, 3'd1, 2'd0, 5'd0, 5'd0, 5'd21, P_A, P_B}, // R10 both zero
    '{4'd11, 3'd7, 2'd0, 5'd3, 5'd4, 5'd22, P_A, P_B}, // R11
    '{4'd9,  3'd0, 2'd0, 5'd3, 5'd4, 5'd0,  P_A, P_B}  // R9
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue = 1'b0;
  logic [2:0]    op = '0;
  logic [1:0]    lsz = '0;
  logic [4:0]    rsi = '0, rti = '0, dst = '0;
  logic [DW-1:0] a = '0, b = '0;
  logic [DW-1:0] res;
  logic [4:0]    dsto;
  logic          wr;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  lane_permute_unit u_dut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .opcode_i(op), .lane_sz_i(lsz),
    .rs_idx_i(rsi), .rt_idx_i(rti), .rs_data_i(a), .rt_data_i(b),
    .dst_idx_i(dst), .result_o(res), .dst_idx_o(dsto), .wr_en_o(wr)
  );

  // Per-bit model of each shuffle, written from the requirements.
  function automatic logic [DW-1:0] model(input logic [2:0] o, input logic [1:0] ls,
                                          input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic [DW-1:0] r;
    int lw;
    r = '0;
    case (o)
      3'd0: r = {x[95:64], x[31:0], y[95:64], y[31:0]};
      3'd1: begin
        lw = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
        for (int k = 0; k < DW; k++) begin
          int lane, bitpos;
          lane   = k / lw;
          bitpos = (lane / 2) * lw + (k % lw);
          r[k]   = (lane % 2 == 1) ? x[bitpos] : y[bitpos];
        end
      end
      3'd2: r = {x[127:96], y[127:96], x[95:64], y[95:64]};
      3'd3: r = {{4{y[79:64]}}, {4{y[15:0]}}};
      3'd4: r = {x[63:0], y[63:0]};
      3'd5: r = {y[127:64], x[127:64]};
      3'd6: r = {y[127:96], y[31:0], y[95:64], y[63:32]};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_vec(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] hold_res;
    logic [DW-1:0] ea, eb;
    // R1: quiet during reset, even with an issue pending.
    issue = 1'b1; op = 3'd0; dst = 5'd5; rsi = 5'd1; rti = 5'd2; a = P_A; b = P_B;
    repeat (3) @(negedge clk);
    check_bit("R1 wr_en during reset", wr, 1'b0);
    issue = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_bit("R1 wr_en after release", wr, 1'b0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      op = VEC[v].op; lsz = VEC[v].lsz; rsi = VEC[v].rsi; rti = VEC[v].rti;
      dst = VEC[v].dst; a = VEC[v].a; b = VEC[v].b; issue = 1'b1;
      ea = (VEC[v].rsi == 5'd0) ? '0 : VEC[v].a;
      eb = (VEC[v].rti == 5'd0) ? '0 : VEC[v].b;
      @(negedge clk);
      issue = 1'b0;
      check_vec($sformatf("R%0d result vec%0d", VEC[v].req, v), res,
                model(VEC[v].op, VEC[v].lsz, ea, eb));
      check_bit($sformatf("R%0d wr_en vec%0d", VEC[v].req, v), wr,
                (VEC[v].dst != 5'd0) && (VEC[v].op != 3'd7));
      if ((VEC[v].dst != 5'd0) && (VEC[v].op != 3'd7))
        check_vec($sformatf("R12 dst vec%0d", v), {123'd0, dsto}, {123'd0, VEC[v].dst});
    end

    // R12: idle cycle holds result and index, drops the write enable.
    op = 3'd5; lsz = 2'd0; rsi = 5'd1; rti = 5'd2; dst = 5'd6; a = P_C; b = P_D; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    hold_res = res;
    check_bit("R12 wr_en after issue", wr, 1'b1);
    a = P_A; b = P_B; dst = 5'd9; op = 3'd0;
    @(negedge clk);
    check_bit("R12 wr_en idle", wr, 1'b0);
    check_vec("R12 result hold", res, hold_res);
    check_vec("R12 dst hold", {123'd0, dsto}, {123'd0, 5'd6});

    // R12: back-to-back issues, each result one cycle later.
    op = 3'd6; rsi = 5'd1; rti = 5'd2; dst = 5'd3; a = P_A; b = P_C; issue = 1'b1;
    @(negedge clk);
    check_vec("R12 back-to-back first", res, model(3'd6, 2'd0, P_A, P_C));
    op = 3'd4; dst = 5'd4;
    @(negedge clk);
    issue = 1'b0;
    check_vec("R12 back-to-back second", res, model(3'd4, 2'd0, P_A, P_C));
    check_bit("R12 back-to-back wr_en", wr, 1'b1);

    // R1: reset asserted mid-run clears the write enable at once.
    op = 3'd0; dst = 5'd2; issue = 1'b1;
    @(posedge clk);
    #2 rst_n = 1'b0;
    #2 check_bit("R1 async reset", wr, 1'b0);
    issue = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule